// File: doc/BRIEF.md
# Timed Serializing Pin Port

This block is a port of up to 32 pins placed between one processor thread and the pins. On the output side, the thread hands over words through a ready/valid handshake, and the port puts them on the pins. In full-width mode, one word drives every pin in one port clock. In the narrow modes, the word is shifted out over several port clocks, one lane-sized chunk per clock. A write can carry a target time. The port then holds the word until a free-running 16-bit tick counter reaches that value. Only then does the first chunk appear.

On the input side, the port samples the pins every port clock once it is armed. In narrow modes it packs successive chunks into a word, and it presents the finished word together with the tick value at which the word's first sample was taken. Arming chooses one of four behaviours: stop capturing, capture everything, or discard samples until the pins equal a compare value (or until they differ from it).

A finished word raises a valid flag that doubles as the thread's wait event. If a newer word finishes before the old one is read, the newer word replaces it and a sticky overrun flag is set.

Top module: `tsio_port`

## Requirements
- R1: While reset is asserted and just after it, `pinsOut` is 0, `txReady` is 1, `rxValid` and `rxOverrun` are 0, `tickNow` is 0, and input capture is stopped.
- R2: `tickNow` increases by one every clock and wraps from 16'hFFFF to 0.
- R3: With `cfgWidth` = 3 (full width), an untimed word accepted at a clock edge is on all 32 pins right after that edge. `txReady` stays high, so one word can be taken every clock.
- R4: With `cfgWidth` = 0, 1 or 2 (1, 4 or 8 bits per clock), an accepted word leaves least significant chunk first on the low pins, one chunk per clock, with the pins above the lane at 0. `txReady` is low until the last chunk is on the pins, and the last chunk then holds.
- R5: A write with `txTimed` = 1 and `txTime` = T puts its first chunk on the pins in exactly the cycle where `tickNow` equals T. Until then the pins keep their old value and `txReady` is low. If T is one past the tick shown at the accepting edge, the word goes out at once.
- R6: Input chunks are the low lane bits of `pinsIn`. The first sampled chunk lands in the least significant bits of `rxData`. `rxValid` rises right after the edge that samples the last chunk. Pins above the lane are ignored.
- R7: `armMode` is applied at an edge where `armValid` = 1, which also clears `rxValid`, `rxOverrun` and the partial word. Mode 0 captures nothing. Mode 1 captures every clock. Mode 2 discards samples until `pinsIn` equals `armValue`, and mode 3 discards them until `pinsIn` differs from it. The matching sample is the first one kept, and capture stays open afterwards.
- R8: `rxStamp` is the `tickNow` value shown in the cycle in which the word's first chunk was sampled.
- R9: A word that completes while `rxValid` is high and `rxReady` is low replaces `rxData` and sets `rxOverrun`. `rxOverrun` stays set until the next arm.
- R10: An edge with `rxValid` and `rxReady` both high clears `rxValid`, unless another word completes at that edge. Without `rxReady`, `rxValid` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; one tick per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWidth | input | 2 | Lane code: 0=1 bit, 1=4 bits, 2=8 bits, 3=full width |
| txValid | input | 1 | Thread offers an output word |
| txReady | output | 1 | Port can take an output word |
| txData | input | 32 | Output word |
| txTimed | input | 1 | Hold the word until the tick matches `txTime` |
| txTime | input | 16 | Tick at which the first chunk must appear |
| pinsOut | output | 32 | Values driven toward the pins |
| pinsIn | input | 32 | Values sampled from the pins |
| armValid | input | 1 | Apply a new capture mode this clock |
| armMode | input | 2 | 0 stop, 1 free, 2 wait for equal, 3 wait for different |
| armValue | input | 32 | Compare value for modes 2 and 3 |
| rxValid | output | 1 | A captured word is waiting (event flag) |
| rxReady | input | 1 | Thread takes the captured word |
| rxData | output | 32 | Captured word |
| rxStamp | output | 16 | Tick of the word's first sample |
| rxOverrun | output | 1 | Sticky: an unread word was replaced |
| tickNow | output | 16 | Free-running port tick counter |

## Verification
Every result lands a fixed number of edges after its cause:
- An untimed output chunk appears right after the edge that accepts the word, and each further chunk appears one edge later than the one before.
- A timed word appears in the first cycle whose tick equals its target.
- A captured word and its stamp appear right after the edge that samples its last chunk.

The bench drives every input one time unit after a rising edge and reads the outputs at that same point. Each check therefore sees the state left by exactly the edges it has counted. Timed output is followed tick by tick, so the check confirms that the pins stay unchanged in every cycle before the target and change in exactly that cycle.

// File: rtl/tsio_pkg.sv
package tsio_pkg;

  typedef enum logic [1:0] {
    LANE_1    = 2'd0,
    LANE_4    = 2'd1,
    LANE_8    = 2'd2,
    LANE_FULL = 2'd3
  } laneMode_e;

  typedef enum logic [1:0] {
    ARM_STOP = 2'd0,
    ARM_FREE = 2'd1,
    ARM_EQ   = 2'd2,
    ARM_NE   = 2'd3
  } armMode_e;

  // strobes from control to datapath, one clock each
  typedef struct packed {
    logic      txCapture;  // word accepted from the thread
    logic      txLoad;     // first chunk goes to the pins
    logic      txShift;    // next chunk goes to the pins
    laneMode_e txMode;     // lane used by a load
    logic      armLoad;    // latch compare value and sense
    logic      rxSample;   // keep this clock's pin sample
    logic      rxFirst;    // sample is the first chunk of a word
    logic      rxComplete; // sample finishes a word
    laneMode_e rxMode;     // lane used for sampling
  } strobes_t;

endpackage

// File: rtl/tsio_tick.sv
module tsio_tick #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [TICK_W-1:0] tickNow,
  output logic [TICK_W-1:0] tickNext
);

  assign tickNext = tickNow + TICK_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickNow <= '0;
    else       tickNow <= tickNext;
  end

endmodule

// File: rtl/tsio_ctrl.sv
module tsio_ctrl
  import tsio_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneMode_e         cfgWidth,
  input  logic              txValid,
  input  logic              txTimed,
  input  logic [TICK_W-1:0] txTime,
  output logic              txReady,
  input  logic [TICK_W-1:0] tickNext,
  input  logic              armValid,
  input  armMode_e          armMode,
  input  logic              condMatch,
  input  logic              rxReady,
  output logic              rxValid,
  output logic              rxOverrun,
  output strobes_t          strb
);

  localparam int CNT_W = $clog2(PINS);

  // index of the last chunk of a word for a lane mode
  function automatic logic [CNT_W-1:0] lastIdx(laneMode_e m);
    case (m)
      LANE_1:  lastIdx = CNT_W'(PINS - 1);
      LANE_4:  lastIdx = CNT_W'(PINS / 4 - 1);
      LANE_8:  lastIdx = CNT_W'(PINS / 8 - 1);
      default: lastIdx = '0;
    endcase
  endfunction

  logic              txWaiting;
  logic [CNT_W-1:0]  txLeft;
  logic [TICK_W-1:0] txTimeReg;
  laneMode_e         txModeReg;
  armMode_e          rxMode;
  logic              gateOpen;
  logic [CNT_W-1:0]  rxCount;

  logic      accept, fireNow, fireLate, sampleOk;
  laneMode_e loadMode;

  always_comb begin
    txReady  = !txWaiting && (txLeft == '0);
    accept   = txValid && txReady;
    loadMode = accept ? cfgWidth : txModeReg;
    fireNow  = accept && (!txTimed || (txTime == tickNext));
    fireLate = txWaiting && (txTimeReg == tickNext);
    sampleOk = !armValid && (rxMode != ARM_STOP) && (gateOpen || condMatch);

    strb            = '0;
    strb.txCapture  = accept;
    strb.txLoad     = fireNow || fireLate;
    strb.txShift    = !(fireNow || fireLate) && (txLeft != '0);
    strb.txMode     = loadMode;
    strb.armLoad    = armValid;
    strb.rxSample   = sampleOk;
    strb.rxFirst    = (rxCount == '0);
    strb.rxComplete = sampleOk && (rxCount == lastIdx(cfgWidth));
    strb.rxMode     = cfgWidth;
  end

  // output side: wait for the scheduled tick, then count chunks down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWaiting <= 1'b0;
      txLeft    <= '0;
      txTimeReg <= '0;
      txModeReg <= LANE_FULL;
    end else begin
      if (accept) begin
        txTimeReg <= txTime;
        txModeReg <= cfgWidth;
      end
      if (accept && !fireNow) txWaiting <= 1'b1;
      else if (fireLate)      txWaiting <= 1'b0;
      if (strb.txLoad)        txLeft <= lastIdx(loadMode);
      else if (strb.txShift)  txLeft <= txLeft - CNT_W'(1);
    end
  end

  // input side: gate, chunk count, valid and overrun
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMode    <= ARM_STOP;
      gateOpen  <= 1'b0;
      rxCount   <= '0;
      rxValid   <= 1'b0;
      rxOverrun <= 1'b0;
    end else if (armValid) begin
      rxMode    <= armMode;
      gateOpen  <= (armMode == ARM_FREE);
      rxCount   <= '0;
      rxValid   <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      if (sampleOk) begin
        gateOpen <= 1'b1;
        rxCount  <= strb.rxComplete ? '0 : rxCount + CNT_W'(1);
      end
      if (strb.rxComplete) begin
        rxValid <= 1'b1;
        if (rxValid && !rxReady) rxOverrun <= 1'b1;
      end else if (rxValid && rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tsio_dpath.sv
module tsio_dpath
  import tsio_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [PINS-1:0]   txData,
  input  armMode_e          armMode,
  input  logic [PINS-1:0]   armValue,
  input  logic [PINS-1:0]   pinsIn,
  input  logic [TICK_W-1:0] tickNow,
  output logic [PINS-1:0]   pinsOut,
  output logic [PINS-1:0]   rxData,
  output logic [TICK_W-1:0] rxStamp,
  output logic              condMatch
);

  function automatic int unsigned laneBits(laneMode_e m);
    case (m)
      LANE_1:  laneBits = 1;
      LANE_4:  laneBits = 4;
      LANE_8:  laneBits = 8;
      default: laneBits = PINS;
    endcase
  endfunction

  function automatic logic [PINS-1:0] laneMask(laneMode_e m);
    case (m)
      LANE_1:  laneMask = PINS'(1);
      LANE_4:  laneMask = PINS'(4'hF);
      LANE_8:  laneMask = PINS'(8'hFF);
      default: laneMask = '1;
    endcase
  endfunction

  logic [PINS-1:0]   holdWord, shiftWord, cmpValue, asmWord;
  logic [PINS-1:0]   srcWord, asmNext;
  laneMode_e         shiftMode;
  logic              cmpNe;
  logic [TICK_W-1:0] stampFirst;

  always_comb begin
    srcWord   = strb.txCapture ? txData : holdWord;
    asmNext   = (asmWord >> laneBits(strb.rxMode))
              | ((pinsIn & laneMask(strb.rxMode)) << (PINS - laneBits(strb.rxMode)));
    condMatch = cmpNe ? (pinsIn != cmpValue) : (pinsIn == cmpValue);
  end

  // output shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord  <= '0;
      shiftWord <= '0;
      shiftMode <= LANE_FULL;
      pinsOut   <= '0;
    end else begin
      if (strb.txCapture) holdWord <= txData;
      if (strb.txLoad) begin
        pinsOut   <= srcWord & laneMask(strb.txMode);
        shiftWord <= srcWord >> laneBits(strb.txMode);
        shiftMode <= strb.txMode;
      end else if (strb.txShift) begin
        pinsOut   <= shiftWord & laneMask(shiftMode);
        shiftWord <= shiftWord >> laneBits(shiftMode);
      end
    end
  end

  // input assembler, compare register and stamp
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpValue   <= '0;
      cmpNe      <= 1'b0;
      asmWord    <= '0;
      stampFirst <= '0;
      rxData     <= '0;
      rxStamp    <= '0;
    end else begin
      if (strb.armLoad) begin
        cmpValue <= armValue;
        cmpNe    <= (armMode == ARM_NE);
      end
      if (strb.rxSample) begin
        asmWord <= asmNext;
        if (strb.rxFirst) stampFirst <= tickNow;
      end
      if (strb.rxComplete) begin
        rxData  <= asmNext;
        rxStamp <= strb.rxFirst ? tickNow : stampFirst;
      end
    end
  end

endmodule

// File: rtl/tsio_port.sv
module tsio_port
  import tsio_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgWidth,
  input  logic              txValid,
  output logic              txReady,
  input  logic [PINS-1:0]   txData,
  input  logic              txTimed,
  input  logic [TICK_W-1:0] txTime,
  output logic [PINS-1:0]   pinsOut,
  input  logic [PINS-1:0]   pinsIn,
  input  logic              armValid,
  input  logic [1:0]        armMode,
  input  logic [PINS-1:0]   armValue,
  output logic              rxValid,
  input  logic              rxReady,
  output logic [PINS-1:0]   rxData,
  output logic [TICK_W-1:0] rxStamp,
  output logic              rxOverrun,
  output logic [TICK_W-1:0] tickNow
);

  strobes_t          strb;
  logic [TICK_W-1:0] tickNext;
  logic              condMatch;

  tsio_tick #(.TICK_W(TICK_W)) i_tick (
    .clk      (clk),
    .rstN     (rstN),
    .tickNow  (tickNow),
    .tickNext (tickNext)
  );

  tsio_ctrl #(.PINS(PINS), .TICK_W(TICK_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWidth  (laneMode_e'(cfgWidth)),
    .txValid   (txValid),
    .txTimed   (txTimed),
    .txTime    (txTime),
    .txReady   (txReady),
    .tickNext  (tickNext),
    .armValid  (armValid),
    .armMode   (armMode_e'(armMode)),
    .condMatch (condMatch),
    .rxReady   (rxReady),
    .rxValid   (rxValid),
    .rxOverrun (rxOverrun),
    .strb      (strb)
  );

  tsio_dpath #(.PINS(PINS), .TICK_W(TICK_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .txData    (txData),
    .armMode   (armMode_e'(armMode)),
    .armValue  (armValue),
    .pinsIn    (pinsIn),
    .tickNow   (tickNow),
    .pinsOut   (pinsOut),
    .rxData    (rxData),
    .rxStamp   (rxStamp),
    .condMatch (condMatch)
  );

endmodule

// File: rtl/tsio_port_chk.sv
module tsio_port_chk #(
  parameter int PINS   = 32,
  parameter int TICK_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        cfgWidth,
  input logic              txValid,
  input logic              txReady,
  input logic [PINS-1:0]   txData,
  input logic              txTimed,
  input logic [TICK_W-1:0] txTime,
  input logic [PINS-1:0]   pinsOut,
  input logic              armValid,
  input logic              rxValid,
  input logic              rxReady,
  input logic              rxOverrun,
  input logic [TICK_W-1:0] tickNow
);

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> tickNow == TICK_W'($past(tickNow) + TICK_W'(1)));

  // R3
  full_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && !txTimed && cfgWidth == 2'd3) |=> pinsOut == $past(txData));

  // R5
  timed_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txTimed && txTime != TICK_W'(tickNow + TICK_W'(1)))
      |=> (!txReady && $stable(pinsOut)));

  // R7
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    armValid |=> (!rxValid && !rxOverrun));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !armValid) |=> rxOverrun);

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !armValid) |=> rxValid);

endmodule

bind tsio_port tsio_port_chk #(.PINS(PINS), .TICK_W(TICK_W)) i_tsio_port_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWidth  (cfgWidth),
  .txValid   (txValid),
  .txReady   (txReady),
  .txData    (txData),
  .txTimed   (txTimed),
  .txTime    (txTime),
  .pinsOut   (pinsOut),
  .armValid  (armValid),
  .rxValid   (rxValid),
  .rxReady   (rxReady),
  .rxOverrun (rxOverrun),
  .tickNow   (tickNow)
);

// File: tb/test_tsio_port.sv
module test_tsio_port;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 6;
  // {word to write, pins to present}
  localparam logic [63:0] VEC [NVEC] = '{
    64'h0000_0000_FFFF_FFFF,
    64'hFFFF_FFFF_0000_0000,
    64'hDEAD_BEEF_1234_5678,
    64'h8000_0001_7FFF_FFFE,
    64'h5555_AAAA_A5A5_5A5A,
    64'h0F0F_F0F0_C001_D00D
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  cfgWidth;
  logic        txValid, txTimed;
  logic        txReady;
  logic [31:0] txData;
  logic [15:0] txTime;
  logic [31:0] pinsOut, pinsIn;
  logic        armValid;
  logic [1:0]  armMode;
  logic [31:0] armValue;
  logic        rxValid, rxReady, rxOverrun;
  logic [31:0] rxData;
  logic [15:0] rxStamp, tickNow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  tsio_port i_tsio_port (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .txTimed(txTimed), .txTime(txTime), .pinsOut(pinsOut), .pinsIn(pinsIn),
    .armValid(armValid), .armMode(armMode), .armValue(armValue),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .rxStamp(rxStamp), .rxOverrun(rxOverrun), .tickNow(tickNow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int laneOf(input logic [1:0] m);
    case (m)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] maskOf(input logic [1:0] m);
    return (m == 2'd3) ? 32'hFFFF_FFFF : ((32'd1 << laneOf(m)) - 32'd1);
  endfunction

  task automatic arm(input logic [1:0] mode, input logic [31:0] value);
    armValid = 1'b1;
    armMode  = mode;
    armValue = value;
    step();
    armValid = 1'b0;
  endtask

  // R4: narrow output shifting
  task automatic txSerial(input logic [1:0] m, input logic [31:0] w);
    int n;
    int lane;
    lane     = laneOf(m);
    n        = 32 / lane;
    cfgWidth = m;
    txData   = w;
    txTimed  = 1'b0;
    txValid  = 1'b1;
    step();
    txValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      chkEq($sformatf("R4 chunk %0d lane %0d", i, lane), pinsOut, (w >> (i * lane)) & maskOf(m));
      chkEq($sformatf("R4 ready chunk %0d lane %0d", i, lane), 32'(txReady), 32'(i == n - 1));
      if (i < n - 1) step();
    end
    step();
    chkEq("R4 last chunk holds", pinsOut, (w >> ((n - 1) * lane)) & maskOf(m));
  endtask

  // R6 / R8 / R10: narrow input packing
  task automatic rxSerial(input logic [1:0] m, input logic [31:0] w);
    int n;
    int lane;
    logic [15:0] t0;
    lane     = laneOf(m);
    n        = 32 / lane;
    cfgWidth = m;
    rxReady  = 1'b1;
    arm(2'd1, 32'h0);
    t0 = tickNow;
    for (int i = 0; i < n; i++) begin
      pinsIn = ~maskOf(m) | ((w >> (i * lane)) & maskOf(m));
      step();
      if (i < n - 1) chkEq($sformatf("R6 no word yet lane %0d", lane), 32'(rxValid), 32'd0);
    end
    chkEq($sformatf("R6 word ready lane %0d", lane), 32'(rxValid), 32'd1);
    chkEq($sformatf("R6 packed word lane %0d", lane), rxData, w);
    chkEq($sformatf("R8 stamp lane %0d", lane), 32'(rxStamp), 32'(t0));
    step();
    chkEq($sformatf("R10 read clears valid lane %0d", lane), 32'(rxValid), 32'd0);
    arm(2'd0, 32'h0);
  endtask

  initial begin
    rstN = 1'b0; cfgWidth = 2'd3; txValid = 1'b0; txTimed = 1'b0;
    txData = '0; txTime = '0; pinsIn = '0; armValid = 1'b0;
    armMode = 2'd0; armValue = '0; rxReady = 1'b1;
    repeat (3) step();
    // R1: state held in reset
    chkEq("R1 pins in reset", pinsOut, 32'h0);
    chkEq("R1 ready in reset", 32'(txReady), 32'd1);
    chkEq("R1 tick in reset", 32'(tickNow), 32'd0);
    rstN = 1'b1;
    step();
    chkEq("R1 rxValid after reset", 32'(rxValid), 32'd0);
    chkEq("R1 overrun after reset", 32'(rxOverrun), 32'd0);
    chkEq("R1 tick first count", 32'(tickNow), 32'd1);
    pinsIn = 32'h1234_0000;
    step();
    step();
    chkEq("R1 capture stopped after reset", 32'(rxValid), 32'd0);

    // R3 / R6 / R8: table of full-width writes and samples
    cfgWidth = 2'd3;
    arm(2'd1, 32'h0);
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] t0;
      txValid = 1'b1;
      txData  = VEC[v][63:32];
      pinsIn  = VEC[v][31:0];
      t0      = tickNow;
      step();
      chkEq($sformatf("R3 pins vec %0d", v), pinsOut, VEC[v][63:32]);
      chkEq($sformatf("R3 ready vec %0d", v), 32'(txReady), 32'd1);
      chkEq($sformatf("R6 valid vec %0d", v), 32'(rxValid), 32'd1);
      chkEq($sformatf("R6 data vec %0d", v), rxData, VEC[v][31:0]);
      chkEq($sformatf("R8 stamp vec %0d", v), 32'(rxStamp), 32'(t0));
    end
    txValid = 1'b0;
    arm(2'd0, 32'h0);

    // R4: narrow output modes
    txSerial(2'd2, 32'hA5C3_1E69);
    txSerial(2'd1, 32'h9E37_79B9);
    txSerial(2'd0, 32'hC35A_0F81);

    // R5: timed output several ticks ahead
    begin
      logic [31:0] old;
      logic [15:0] t;
      int waited;
      cfgWidth = 2'd3;
      old      = pinsOut;
      t        = tickNow + 16'd6;
      txData   = 32'h7E57_0A11;
      txTimed  = 1'b1;
      txTime   = t;
      txValid  = 1'b1;
      step();
      txValid = 1'b0;
      txTimed = 1'b0;
      chkEq("R5 ready low while waiting", 32'(txReady), 32'd0);
      waited = 0;
      for (int g = 0; g < 20 && tickNow != t; g++) begin
        chkEq("R5 pins hold before target", pinsOut, old);
        waited++;
        step();
      end
      chkEq("R5 cycles waited", 32'(waited), 32'd5);
      chkEq("R5 pins at target tick", pinsOut, 32'h7E57_0A11);
      chkEq("R5 ready after launch", 32'(txReady), 32'd1);
      // R5: target one past the current tick goes out at once
      t       = tickNow + 16'd1;
      txData  = 32'h0BAD_F00D;
      txTimed = 1'b1;
      txTime  = t;
      txValid = 1'b1;
      step();
      txValid = 1'b0;
      txTimed = 1'b0;
      chkEq("R5 immediate target pins", pinsOut, 32'h0BAD_F00D);
      chkEq("R5 immediate target tick", 32'(tickNow), 32'(t));
    end

    // R6 / R8 / R10: narrow input modes
    rxSerial(2'd2, 32'h3C4D_5E6F);
    rxSerial(2'd1, 32'hF1E2_D3C4);
    rxSerial(2'd0, 32'h8421_7BDE);

    // R7: wait for equal, then stay open
    begin
      logic [15:0] t0;
      cfgWidth = 2'd3;
      rxReady  = 1'b1;
      pinsIn   = 32'h1111_1111;
      arm(2'd2, 32'hCAFE_0001);
      step();
      chkEq("R7 eq discards mismatch", 32'(rxValid), 32'd0);
      pinsIn = 32'h0;
      step();
      chkEq("R7 eq discards second mismatch", 32'(rxValid), 32'd0);
      pinsIn = 32'hCAFE_0001;
      t0     = tickNow;
      step();
      chkEq("R7 eq match captured", rxData, 32'hCAFE_0001);
      chkEq("R8 eq match stamp", 32'(rxStamp), 32'(t0));
      pinsIn = 32'h2222_3333;
      step();
      chkEq("R7 eq stays open valid", 32'(rxValid), 32'd1);
      chkEq("R7 eq stays open data", rxData, 32'h2222_3333);
    end

    // R7: wait for different
    begin
      logic [15:0] t0;
      pinsIn = 32'h4444_4444;
      arm(2'd3, 32'h4444_4444);
      step();
      step();
      chkEq("R7 ne discards equal", 32'(rxValid), 32'd0);
      pinsIn = 32'h4444_4445;
      t0     = tickNow;
      step();
      chkEq("R7 ne change captured", rxData, 32'h4444_4445);
      chkEq("R8 ne stamp", 32'(rxStamp), 32'(t0));
    end

    // R7: stop mode captures nothing
    arm(2'd0, 32'h0);
    for (int i = 0; i < 3; i++) begin
      pinsIn = 32'h1000_0000 + 32'(i);
      step();
      chkEq("R7 stop mode idle", 32'(rxValid), 32'd0);
    end

    // R9 / R10: overrun and hold without read
    rxReady = 1'b0;
    arm(2'd1, 32'h0);
    pinsIn = 32'hAAAA_0001;
    step();
    chkEq("R9 first word", rxData, 32'hAAAA_0001);
    chkEq("R9 no overrun yet", 32'(rxOverrun), 32'd0);
    pinsIn = 32'hAAAA_0002;
    step();
    chkEq("R9 replaced word", rxData, 32'hAAAA_0002);
    chkEq("R9 overrun set", 32'(rxOverrun), 32'd1);
    pinsIn = 32'hAAAA_0003;
    step();
    chkEq("R10 valid held unread", 32'(rxValid), 32'd1);
    chkEq("R9 overrun sticky", 32'(rxOverrun), 32'd1);
    rxReady = 1'b1;
    arm(2'd0, 32'h0);
    chkEq("R7 arm clears overrun", 32'(rxOverrun), 32'd0);
    chkEq("R7 arm clears valid", 32'(rxValid), 32'd0);

    // R2: step and wrap of the tick counter
    begin
      logic [15:0] t0;
      t0 = tickNow;
      step();
      chkEq("R2 tick step", 32'(tickNow), 32'(t0 + 16'd1));
      for (int g = 0; g < 70000 && tickNow != 16'hFFFF; g++) step();
      chkEq("R2 reached top", 32'(tickNow), 32'hFFFF);
      step();
      chkEq("R2 wrap to zero", 32'(tickNow), 32'd0);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule